// File: doc/BRIEF.md
# Serial Two-Wire Byte Memory Slave

This block is the bus-side controller of a small nonvolatile byte memory that answers on a two-wire I2C bus as a slave. It oversamples SCL and SDA with the system clock and finds START and STOP conditions. It accepts only the one hard-wired device code. It takes a word address, latches written bytes into a small staging buffer, and returns data bytes on reads. SDA is open-drain, so the block only produces a pull-low enable. The bus resolves the wired line.

Written bytes never go straight into the array. A STOP that closes a write with staged bytes starts a timed programming cycle. The staged bytes reach the array only when that cycle has run its full length. Until then the block ignores the bus completely. A mode input chooses how staged bytes map to addresses. With mode high, a short run of bytes goes to consecutive addresses. With mode low, a longer run wraps inside an aligned page. A power-on-reset input holds the block silent and discards any staged bytes. The array behind it is a plain synchronous memory with one write port and one read port.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After `rst` the block is idle and `sda_pull_o` is low. The array contents are not reset.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bits clocked while idle without a preceding START get no acknowledge.
- R3: After START the block shifts in eight bits, most significant first. If the upper seven bits are 1010000 (select byte 0xA0 for write, 0xA1 for read), it pulls SDA low for the whole ninth clock.
- R4: A select byte whose upper seven bits differ from 1010000 gets no acknowledge, and every following byte is ignored without acknowledge until the next START.
- R5: After a select with bit 0 = 0, the next byte becomes the current address and is acknowledged. Each further byte is acknowledged and staged.
- R6: A select with bit 0 = 1 returns the byte at the current address, MSB first, with the address incrementing after each byte and wrapping from 0xFF to 0x00. A master acknowledge (SDA low on the ninth clock) continues the read. A master no-acknowledge ends it, and a STOP then returns the block to idle.
- R7: With `mode_i` high when the address byte is acknowledged, staged byte k goes to slot k mod 4 and slot s is written at address base+s modulo 256. A fifth byte replaces the first one.
- R8: With `mode_i` low when the address byte is acknowledged, staged byte k goes to slot k mod 8 and slot s is written at the address whose upper five bits are those of the base and whose low three bits are (base+s) mod 8. A ninth byte replaces the first one.
- R9: Programming starts only at a STOP with at least one staged byte. It lasts WRITE_CYCLES clocks before the staged bytes are written. A STOP after an address with no data starts no programming.
- R10: While programming runs, the block acknowledges nothing and detects no START or STOP.
- R11: While `por` is high the block never pulls SDA, ignores the bus, and drops staged bytes, so a later STOP programs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| por | input | 1 | Power-on-reset hold, active high |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| mode_i | input | 1 | Write mapping select: 1 consecutive run of four, 0 page of eight |
| sda_pull_o | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
The bench attacks the slot mapping. It writes five bytes in consecutive mode across a 0x3F to 0x40 boundary and nine bytes in page mode from a mid-page base. A design that shifted instead of overwriting, or that carried out of the page, returns the wrong byte at the first address or spills into the next page. It starts a new transfer right after a write STOP, which a design that is not deaf during programming would acknowledge. It also starts one right after an address-only STOP, which a design that programs needlessly would refuse. A read that crosses 0xFF catches a missing wrap. A power-on-reset pulse between staged data and STOP exposes a design that still commits the dropped bytes.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DACK,
    ST_ADR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_WAIT,
    ST_PROG,
    ST_COMMIT
  } eep_state_t;

  localparam logic [6:0] DEV_CODE = 7'b1010000;
  localparam int BYTE_W = 8;

endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_pipe;
  logic [TOP:0] sda_pipe;
  logic         scl_d;
  logic         sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
      sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
      scl_d    <= scl_pipe[TOP];
      sda_d    <= sda_pipe[TOP];
    end
  end

  assign scl_s     = scl_pipe[TOP];
  assign sda_s     = sda_pipe[TOP];
  assign scl_rise  = ~scl_d & scl_s;
  assign scl_fall  = scl_d & ~scl_s;
  assign start_det = scl_d & scl_s & sda_d & ~sda_s;
  assign stop_det  = scl_d & scl_s & ~sda_d & sda_s;

endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/eep_wbuf.sv
module eep_wbuf #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int PAGE_SLOTS  = 8,
  parameter int MULTI_SLOTS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          push,
  input  logic [DW-1:0]                 din,
  input  logic                          multi,
  input  logic [AW-1:0]                 base,
  input  logic [$clog2(PAGE_SLOTS)-1:0] rd_slot,
  output logic [DW-1:0]                 rd_data,
  output logic [AW-1:0]                 rd_addr,
  output logic                          rd_valid,
  output logic                          any_valid
);

  localparam int SW = $clog2(PAGE_SLOTS);
  localparam logic [SW-1:0] PAGE_LAST  = SW'(PAGE_SLOTS - 1);
  localparam logic [SW-1:0] MULTI_LAST = SW'(MULTI_SLOTS - 1);

  logic [DW-1:0]         slot_data [PAGE_SLOTS];
  logic [PAGE_SLOTS-1:0] slot_vld;
  logic [SW-1:0]         wptr;
  logic [SW-1:0]         last_slot;
  logic [SW-1:0]         page_low;

  assign last_slot = multi ? MULTI_LAST : PAGE_LAST;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      slot_vld <= '0;
      wptr     <= '0;
    end else if (push) begin
      slot_vld[wptr] <= 1'b1;
      wptr           <= (wptr == last_slot) ? '0 : wptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_data[wptr] <= din;
  end

  assign page_low  = base[SW-1:0] + rd_slot;
  assign rd_addr   = multi ? (base + AW'(rd_slot)) : {base[AW-1:SW], page_low};
  assign rd_data   = slot_data[rd_slot];
  assign rd_valid  = slot_vld[rd_slot];
  assign any_valid = |slot_vld;

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter int AW           = 8,
  parameter int PAGE_SLOTS   = 8,
  parameter int MULTI_SLOTS  = 4,
  parameter int WRITE_CYCLES = 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic scl_i,
  input  logic sda_i,
  input  logic mode_i,
  output logic sda_pull_o
);

  localparam int SW = $clog2(PAGE_SLOTS);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(PAGE_SLOTS - 1);
  localparam logic [CW-1:0] CYC_LAST  = CW'(WRITE_CYCLES - 1);

  eep_state_t          state;
  logic                scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [3:0]          bit_cnt;
  logic [BYTE_W-1:0]   shreg;
  logic [BYTE_W-1:0]   tx;
  logic [AW-1:0]       cur_addr;
  logic [AW-1:0]       base;
  logic                mode_q;
  logic                rw_q;
  logic [CW-1:0]       cyc;
  logic [SW-1:0]       slot;
  logic                buf_clr;
  logic                push;
  logic                busy;
  logic                byte_end;
  logic [BYTE_W-1:0]   mem_rdata;
  logic [BYTE_W-1:0]   buf_data;
  logic [AW-1:0]       buf_addr;
  logic                buf_valid;
  logic                buf_any;
  logic                mem_we;

  eep_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign busy     = (state == ST_PROG) || (state == ST_COMMIT);
  assign byte_end = scl_fall && (bit_cnt == 4'd8);
  assign push     = (state == ST_WDAT) && byte_end && !start_det && !stop_det && !por;
  assign mem_we   = (state == ST_COMMIT) && buf_valid && !por;

  eep_wbuf #(
    .AW          (AW),
    .DW          (BYTE_W),
    .PAGE_SLOTS  (PAGE_SLOTS),
    .MULTI_SLOTS (MULTI_SLOTS)
  ) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .clr       (buf_clr),
    .push      (push),
    .din       (shreg),
    .multi     (mode_q),
    .base      (base),
    .rd_slot   (slot),
    .rd_data   (buf_data),
    .rd_addr   (buf_addr),
    .rd_valid  (buf_valid),
    .any_valid (buf_any)
  );

  eep_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (buf_addr),
    .wdata (buf_data),
    .raddr (cur_addr),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || por) begin
      state      <= ST_IDLE;
      sda_pull_o <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      tx         <= '0;
      cyc        <= '0;
      slot       <= '0;
      buf_clr    <= 1'b1;
      rw_q       <= 1'b0;
      if (rst) begin
        cur_addr <= '0;
        base     <= '0;
        mode_q   <= 1'b1;
      end
    end else begin
      buf_clr <= 1'b0;
      if (busy) begin
        sda_pull_o <= 1'b0;
        if (state == ST_PROG) begin
          if (cyc == CYC_LAST) begin
            state <= ST_COMMIT;
            slot  <= '0;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end else begin
          if (slot == SLOT_LAST) begin
            state   <= ST_IDLE;
            buf_clr <= 1'b1;
          end
          slot <= slot + 1'b1;
        end
      end else if (start_det) begin
        state      <= ST_DEV;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
        buf_clr    <= 1'b1;
      end else if (stop_det) begin
        sda_pull_o <= 1'b0;
        cyc        <= '0;
        state      <= buf_any ? ST_PROG : ST_IDLE;
      end else begin
        unique case (state)
          ST_DEV, ST_ADR, ST_WDAT: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_end) begin
              if (state == ST_DEV) begin
                if (shreg[BYTE_W-1:1] == DEV_CODE) begin
                  sda_pull_o <= 1'b1;
                  rw_q       <= shreg[0];
                  state      <= ST_DACK;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_ADR) begin
                sda_pull_o <= 1'b1;
                cur_addr   <= shreg[AW-1:0];
                base       <= shreg[AW-1:0];
                mode_q     <= mode_i;
                buf_clr    <= 1'b1;
                state      <= ST_AACK;
              end else begin
                sda_pull_o <= 1'b1;
                state      <= ST_WACK;
              end
            end
          end
          ST_DACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                tx         <= mem_rdata;
                sda_pull_o <= ~mem_rdata[BYTE_W-1];
                state      <= ST_RDAT;
              end else begin
                sda_pull_o <= 1'b0;
                state      <= ST_ADR;
              end
            end
          end
          ST_AACK, ST_WACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              bit_cnt    <= '0;
              state      <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise && bit_cnt != 4'd8) bit_cnt <= bit_cnt + 1'b1;
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_pull_o <= 1'b0;
                cur_addr   <= cur_addr + 1'b1;
                state      <= ST_RACK;
              end else begin
                sda_pull_o <= ~tx[BYTE_W-2];
                tx         <= tx << 1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise && sda_s) begin
              state <= ST_WAIT;
            end else if (scl_fall) begin
              tx         <= mem_rdata;
              sda_pull_o <= ~mem_rdata[BYTE_W-1];
              bit_cnt    <= '0;
              state      <= ST_RDAT;
            end
          end
          default: begin
            sda_pull_o <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int WRITE_CYCLES = 500
) (
  input logic clk,
  input logic rst,
  input logic por,
  input logic scl_s,
  input logic stop_det,
  input logic sda_pull,
  input logic busy
);

  localparam int CW = $clog2(WRITE_CYCLES + 2);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || por || !busy) busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
  end

  // R1: released line right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) && !rst |-> !sda_pull);

  // R11: power-on-reset silences the line
  a_r11_por_silent: assert property (@(posedge clk) disable iff (rst)
    por |=> !sda_pull);

  // R10: no drive while programming
  a_r10_deaf_busy: assert property (@(posedge clk) disable iff (rst || por)
    busy |-> !sda_pull);

  // R3: line changes only while SCL is low
  a_r3_change_scl_low: assert property (@(posedge clk) disable iff (rst || por)
    !$stable(sda_pull) && !$past(por) && !$past(rst) |-> !$past(scl_s));

  // R9: programming begins only at a STOP
  a_r9_prog_at_stop: assert property (@(posedge clk) disable iff (rst || por)
    $rose(busy) |-> $past(stop_det));

  // R9: programming lasts at least the write time
  a_r9_prog_length: assert property (@(posedge clk) disable iff (rst || por)
    $fell(busy) && !$past(por) |-> busy_cnt >= CW'(WRITE_CYCLES));

endmodule

bind i2c_eeprom_slave eep_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .por      (por),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .sda_pull (sda_pull_o),
  .busy     (busy)
);

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;

  localparam int WC = 500;
  localparam int Q  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic mode = 1'b1;
  logic pull;
  logic sda;
  bit   done = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      tag_q[$];
  logic [7:0] model [256];
  logic [7:0] wq[$];

  assign sda = ~(m_low | pull);

  always #5 clk = ~clk;

  i2c_eeprom_slave #(.WRITE_CYCLES(WC)) u0 (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .scl_i      (scl),
    .sda_i      (sda),
    .mode_i     (mode),
    .sda_pull_o (pull)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    obs_q.push_back(act);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a;
        logic [7:0] e;
        string      t;
        a = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", t, a, e);
        end
      end
    end
  end

  task automatic i2c_start();
    m_low = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    m_low = 1'b1; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    m_low = 1'b0; wait_clk(Q);
  endtask

  task automatic wbit(input logic b);
    m_low = ~b;  wait_clk(Q);
    scl = 1'b1;  wait_clk(2 * Q);
    scl = 1'b0;  wait_clk(Q);
  endtask

  task automatic rbit(output logic b);
    m_low = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    b = sda;      wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic nack;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(nack);
    ack = ~nack;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~give_ack);
  endtask

  // writes wq starting at base, then updates the model from R7/R8 rules
  task automatic write_txn(input logic m, input logic [7:0] base, input string tag);
    logic       ack;
    logic [7:0] sv [8];
    bit         used [8];
    logic [7:0] a;
    int         slots;
    mode = m;
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h01, "R3 select ack");
    wbyte(base, ack);  chk({7'b0, ack}, 8'h01, "R5 address ack");
    foreach (wq[k]) begin
      wbyte(wq[k], ack); chk({7'b0, ack}, 8'h01, {tag, " data ack"});
    end
    i2c_stop();
    slots = m ? 4 : 8;
    for (int s = 0; s < 8; s++) used[s] = 1'b0;
    foreach (wq[k]) begin
      sv[k % slots]   = wq[k];
      used[k % slots] = 1'b1;
    end
    for (int s = 0; s < slots; s++) begin
      if (used[s]) begin
        a = m ? base + 8'(s) : {base[7:3], base[2:0] + 3'(s)};
        model[a] = sv[s];
      end
    end
    wait_clk(WC + 40);
  endtask

  task automatic read_seq(input logic [7:0] addr, input int n, input string tag);
    logic       ack;
    logic [7:0] d;
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h01, "R3 select ack before read");
    wbyte(addr, ack);  chk({7'b0, ack}, 8'h01, "R5 address ack before read");
    i2c_start();
    wbyte(8'hA1, ack); chk({7'b0, ack}, 8'h01, "R6 read select ack");
    for (int i = 0; i < n; i++) begin
      rbyte(d, i < n - 1);
      chk(d, model[8'(addr + 8'(i))], tag);
    end
    i2c_stop();
    wait_clk(4 * Q);
  endtask

  initial begin
    logic ack;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    chk({7'b0, pull}, 8'h00, "R1 line released after reset");

    // R2: bits without START get no acknowledge
    scl = 1'b0; wait_clk(Q);
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h00, "R2 no ack without START");
    scl = 1'b1; m_low = 1'b0; wait_clk(2 * Q);

    // R9/R10: single write, then new transfer during programming
    mode = 1'b1;
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h01, "R3 select ack");
    wbyte(8'h10, ack); chk({7'b0, ack}, 8'h01, "R5 address ack");
    wbyte(8'hA5, ack); chk({7'b0, ack}, 8'h01, "R5 data ack");
    i2c_stop();
    model[8'h10] = 8'hA5;
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h00, "R10 no ack while programming");
    i2c_stop();
    wait_clk(WC + 40);
    read_seq(8'h10, 1, "R9 committed byte");

    // R4: wrong device code, then following byte also ignored
    i2c_start();
    wbyte(8'hA2, ack); chk({7'b0, ack}, 8'h00, "R4 wrong code nack");
    wbyte(8'h55, ack); chk({7'b0, ack}, 8'h00, "R4 ignored until START");
    i2c_stop();
    wait_clk(2 * Q);
    i2c_start();
    wbyte(8'hB0, ack); chk({7'b0, ack}, 8'h00, "R4 other wrong code nack");
    i2c_stop();
    wait_clk(2 * Q);

    // R9: address-only STOP starts no programming
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h01, "R3 select ack");
    wbyte(8'h20, ack); chk({7'b0, ack}, 8'h01, "R5 address ack");
    i2c_stop();
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h01, "R9 no cycle after address-only STOP");
    i2c_stop();
    wait_clk(2 * Q);

    // R7: consecutive run of four, fifth replaces first
    wq.delete();
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
    wq.push_back(8'h44); wq.push_back(8'h55);
    write_txn(1'b1, 8'h3E, "R7");
    read_seq(8'h3E, 4, "R7 consecutive mapping");

    // R8: page of eight, low bits wrap, ninth replaces first
    wq.delete();
    for (int k = 0; k < 9; k++) wq.push_back(8'h80 + 8'(k));
    write_txn(1'b0, 8'h26, "R8");
    read_seq(8'h20, 8, "R8 page mapping");

    // R6: address wrap from 0xFF to 0x00
    wq.delete();
    wq.push_back(8'h5A); wq.push_back(8'hC3);
    write_txn(1'b1, 8'hFF, "R7 wrap");
    read_seq(8'hFF, 2, "R6 read wraps at 0xFF");

    // R11: silent under power-on-reset
    wq.delete();
    wq.push_back(8'h11);
    write_txn(1'b1, 8'h50, "R5");
    por = 1'b1;
    wait_clk(4);
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h00, "R11 no ack under por");
    i2c_stop();
    por = 1'b0;
    wait_clk(4);

    // R11: staged data dropped by por pulse
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h01, "R3 select ack");
    wbyte(8'h50, ack); chk({7'b0, ack}, 8'h01, "R5 address ack");
    wbyte(8'h77, ack); chk({7'b0, ack}, 8'h01, "R5 data ack");
    m_low = 1'b1;
    por = 1'b1;
    wait_clk(10);
    por = 1'b0;
    wait_clk(4);
    i2c_stop();
    i2c_start();
    wbyte(8'hA0, ack); chk({7'b0, ack}, 8'h01, "R11 no cycle after por drop");
    i2c_stop();
    wait_clk(2 * Q);
    read_seq(8'h50, 1, "R11 dropped byte not written");

    wait_clk(20);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard left %0d unmatched items, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule